// File: doc/BRIEF.md
# E3 Frame Alignment State Machine

This block locks onto the frame structure of a serial E3 receive bit stream. Each frame is 1536 bits long and opens with a 10-bit alignment word. The block has three states. In the hunt state it searches bit by bit for the alignment word. In the check state it confirms that the word comes back one frame later. In the locked state it tracks frame boundaries and counts frames whose alignment word is corrupted.

The out-of-frame level (`oof_o`) is high in the hunt and check states and low in the locked state. An interrupt block elsewhere watches it for changes. A one-cycle frame-start pulse marks the first bit of every frame while locked. The state code is also driven out.

A locked block falls back to the hunt state after the fourth errored frame in a row. It keeps its old bit phase when it does so. If the alignment word then shows up again at that same phase, the block returns straight to the locked state and skips the check. A word found at any other phase goes through the check state as usual.

Top module: `e3fa_aligner`

## Requirements
- R1: Reset (active-low, asynchronous) puts the block in the hunt state (state code 0) with `oof_o` high and clears any retained frame phase.
- R2: In hunt with no retained phase, the block checks every valid bit for the word 1111010000. The leftmost bit arrives first and sits at frame bit 0, so the word fills frame bits 0 to 9. A match moves the block to the check state (code 1), with the matching bit taken as frame bit 9.
- R3: In the check state, a match at frame bit 9 of the next frame moves the block to locked (code 2) and drops `oof_o`. A mismatch there returns it to hunt and discards the retained phase.
- R4: While locked, each frame whose word mismatches increments a run counter, and each correct frame clears it. A locked block never moves to the check state.
- R5: Three errored frames in a row leave the block locked. The fourth errored frame in a row moves it to hunt with `oof_o` high, and its bit phase is kept.
- R6: In hunt with a retained phase, a match at retained frame bit 9 moves the block directly to locked.
- R7: In hunt with a retained phase, a match at any other bit moves the block to the check state and re-phases the frame counter.
- R8: While locked, `frame_start_o` is high for one cycle, in the cycle that presents frame bit 0. It is low in every other cycle and in every other state.
- R9: Cycles with `bit_vld_i` low are ignored: the state, the frame position and the alignment-word window do not advance, and the data bit in those cycles has no effect.
- R10: `oof_o` is high in state codes 0 and 1 and low in code 2. Code 3 never occurs. The frame length is 1536 valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial receive data bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` in this cycle |
| oof_o | output | 1 | Out-of-frame level |
| frame_start_o | output | 1 | One-cycle pulse on frame bit 0 while locked |
| state_o | output | 2 | State code: 0 hunt, 1 check, 2 locked |

## Verification
The hardest case to reach is the direct return from hunt to locked. It needs a retained phase, and that phase exists only after a locked period followed by exactly four errored frames in a row. The stimulus table builds that history in order: it locks, breaks the error run with one good frame, lets four bad frames through, and then sends one good frame at the old phase. The same table then shows the opposite case. A single failed check discards the phase, so a following good frame at that same phase must go through the check state rather than straight to locked.

// File: rtl/e3fa_pkg.sv
package e3fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_SYNC   = 2'd2
  } fa_state_e;
endpackage

// File: rtl/e3fa_fas_det.sv
module e3fa_fas_det #(
  parameter int          FAS_W = 10,
  parameter logic [FAS_W-1:0] FAS_PAT = 10'b1111010000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic vld_i,
  output logic match_o
);
  logic [FAS_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (vld_i) sh_q <= {sh_q[FAS_W-3:0], bit_i};
  end

  // window includes the bit presented this cycle
  assign match_o = vld_i && ({sh_q, bit_i} == FAS_PAT);
endmodule

// File: rtl/e3fa_pos_cnt.sv
module e3fa_pos_cnt #(
  parameter int FRAME_LEN = 1536,
  parameter int FAS_W     = 10,
  localparam int POS_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] LOAD_POS = POS_W'(FAS_W);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (adv_i) begin
      if (load_i)                pos_q <= LOAD_POS;
      else if (pos_q == LAST_POS) pos_q <= '0;
      else                       pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/e3fa_err_cnt.sv
module e3fa_err_cnt #(
  parameter int  ERR_LIMIT = 4,
  localparam int ERR_W     = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [ERR_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [ERR_W-1:0] LAST_CNT = ERR_W'(ERR_LIMIT - 1);

  logic [ERR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_CNT);
endmodule

// File: rtl/e3fa_aligner.sv
module e3fa_aligner
  import e3fa_pkg::*;
#(
  parameter int FRAME_LEN = 1536,
  parameter int FAS_W     = 10,
  parameter logic [FAS_W-1:0] FAS_PAT = 10'b1111010000,
  parameter int ERR_LIMIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  output logic       oof_o,
  output logic       frame_start_o,
  output logic [1:0] state_o
);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam int ERR_W = $clog2(ERR_LIMIT + 1);
  localparam logic [POS_W-1:0] CHK_POS = POS_W'(FAS_W - 1);

  fa_state_e        st_q, st_d;
  logic             aln_q, aln_d;
  logic             match, load, at_chk;
  logic             err_clr, err_inc, err_last;
  logic [POS_W-1:0] pos;
  logic [ERR_W-1:0] err_cnt;

  e3fa_fas_det #(.FAS_W(FAS_W), .FAS_PAT(FAS_PAT)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .vld_i(bit_vld_i),
    .match_o(match)
  );

  e3fa_pos_cnt #(.FRAME_LEN(FRAME_LEN), .FAS_W(FAS_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(bit_vld_i), .load_i(load),
    .pos_o(pos)
  );

  e3fa_err_cnt #(.ERR_LIMIT(ERR_LIMIT)) u_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(err_clr), .inc_i(err_inc),
    .cnt_o(err_cnt), .last_o(err_last)
  );

  assign at_chk = bit_vld_i && (pos == CHK_POS);

  always_comb begin
    st_d    = st_q;
    aln_d   = aln_q;
    load    = 1'b0;
    err_clr = 1'b0;
    err_inc = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        err_clr = 1'b1;
        if (match) begin
          if (aln_q && at_chk) st_d = ST_SYNC;   // back at retained phase
          else begin
            st_d  = ST_VERIFY;
            load  = 1'b1;
            aln_d = 1'b1;
          end
        end
      end
      ST_VERIFY: begin
        err_clr = 1'b1;
        if (at_chk) begin
          if (match) st_d = ST_SYNC;
          else begin
            st_d  = ST_HUNT;
            aln_d = 1'b0;
          end
        end
      end
      ST_SYNC: begin
        if (at_chk) begin
          if (match) err_clr = 1'b1;
          else if (err_last) begin
            st_d    = ST_HUNT;
            err_clr = 1'b1;
          end else err_inc = 1'b1;
        end
      end
      default: begin
        st_d  = ST_HUNT;
        aln_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      aln_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      aln_q <= aln_d;
    end
  end

  assign state_o       = st_q;
  assign oof_o         = (st_q != ST_SYNC);
  assign frame_start_o = bit_vld_i && (st_q == ST_SYNC) && (pos == '0);
endmodule

// File: rtl/e3fa_aligner_chk.sv
module e3fa_aligner_chk #(
  parameter int  ERR_LIMIT = 4,
  localparam int ERR_W     = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             oof_o,
  input  logic             frame_start_o,
  input  logic [1:0]       state_o,
  input  logic [ERR_W-1:0] err_cnt
);
  localparam logic [ERR_W-1:0] LAST_CNT = ERR_W'(ERR_LIMIT - 1);

  assert_state_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(state_o));

  assert_pulse_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  assert_pulse_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !oof_o);

  assert_no_sync_to_verify_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |=> state_o != 2'd1);

  assert_loss_at_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && err_cnt != LAST_CNT) |=> state_o == 2'd2);

  assert_err_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt <= LAST_CNT);

  assert_clear_on_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oof_o) |-> $past(bit_vld_i));
endmodule

bind e3fa_aligner e3fa_aligner_chk #(.ERR_LIMIT(ERR_LIMIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .oof_o(oof_o),
  .frame_start_o(frame_start_o), .state_o(state_o), .err_cnt(err_cnt)
);

// File: tb/e3fa_aligner_bench.sv
`timescale 1ns/1ps
module e3fa_aligner_bench;
  localparam int FLEN = 1536;
  localparam logic [9:0] PAT = 10'b1111010000;
  localparam int NV = 18;
  // {slip[5:0], gaps, fas_ok, exp_state[1:0]}
  localparam logic [9:0] VEC [NV] = '{
    {6'd50, 1'b0, 1'b1, 2'd1},  // R2 first word found -> check
    {6'd0,  1'b0, 1'b1, 2'd2},  // R3 recurs -> locked
    {6'd0,  1'b0, 1'b0, 2'd2},  // R4 err 1
    {6'd0,  1'b1, 1'b0, 2'd2},  // R9 err 2 with idle gaps
    {6'd0,  1'b0, 1'b1, 2'd2},  // R4 good frame clears run
    {6'd0,  1'b0, 1'b0, 2'd2},  // R5 err 1
    {6'd0,  1'b0, 1'b0, 2'd2},  // R5 err 2
    {6'd0,  1'b0, 1'b0, 2'd2},  // R5 err 3
    {6'd0,  1'b0, 1'b0, 2'd0},  // R5 err 4 -> hunt
    {6'd0,  1'b0, 1'b1, 2'd2},  // R6 direct return
    {6'd0,  1'b0, 1'b0, 2'd2},
    {6'd0,  1'b0, 1'b0, 2'd2},
    {6'd0,  1'b0, 1'b0, 2'd2},
    {6'd0,  1'b0, 1'b0, 2'd0},  // R5 -> hunt again
    {6'd37, 1'b0, 1'b1, 2'd1},  // R7 new phase -> check
    {6'd0,  1'b0, 1'b0, 2'd0},  // R3 check fails
    {6'd0,  1'b0, 1'b1, 2'd1},  // R3 phase discarded -> check
    {6'd0,  1'b1, 1'b1, 2'd2}   // R9 gaps across word -> locked
  };

  logic clk = 1'b0, rst_ni = 1'b0, bit_i = 1'b0, bit_vld_i = 1'b0;
  logic oof_o, frame_start_o;
  logic [1:0] state_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  e3fa_aligner u_e3fa_aligner (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .oof_o(oof_o), .frame_start_o(frame_start_o), .state_o(state_o)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output bit fs);
    @(negedge clk);
    bit_i = b; bit_vld_i = 1'b1;
    #1 fs = frame_start_o;
  endtask

  task automatic idle;
    @(negedge clk);
    bit_vld_i = 1'b0; bit_i = 1'b1;
  endtask

  task automatic send_frame(input int slip, input bit gaps, input bit ok,
                            output int pulses, output bit at0);
    bit fs;
    pulses = 0; at0 = 1'b0;
    for (int i = 0; i < slip; i++) begin
      send_bit(1'b0, fs);
      if (fs) pulses++;
    end
    for (int i = 0; i < FLEN; i++) begin
      send_bit((ok && i < 10) ? PAT[9-i] : 1'b0, fs);
      if (fs) begin
        pulses++;
        if (i == 0) at0 = 1'b1;
      end
      if (gaps && i < 200 && (i % 3) == 2) idle();
    end
    @(negedge clk);
    bit_vld_i = 1'b0;
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int pulses;
    bit at0;
    int prev_st;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(state_o == 2'd0, "R1 reset state", state_o, 0);
    check(oof_o == 1'b1, "R1 reset oof", oof_o, 1);
    check(frame_start_o == 1'b0, "R8 no pulse after reset", frame_start_o, 0);

    prev_st = 0;
    for (int v = 0; v < NV; v++) begin
      send_frame(int'(VEC[v][9:4]), VEC[v][3], VEC[v][2], pulses, at0);
      check(state_o == VEC[v][1:0], $sformatf("R2-table state row %0d", v),
            state_o, VEC[v][1:0]);
      check(oof_o == (VEC[v][1:0] != 2'd2), $sformatf("R10 oof row %0d", v),
            oof_o, VEC[v][1:0] != 2'd2);
      check(pulses == (prev_st == 2 ? 1 : 0), $sformatf("R8 pulse count row %0d", v),
            pulses, prev_st == 2 ? 1 : 0);
      if (prev_st == 2)
        check(at0, $sformatf("R8 pulse on bit 0 row %0d", v), at0, 1);
      prev_st = VEC[v][1:0];
    end

    // R1: reset while locked discards the phase
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(state_o == 2'd0, "R1 async reset state", state_o, 0);
    check(oof_o == 1'b1, "R1 async reset oof", oof_o, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    send_frame(0, 1'b0, 1'b1, pulses, at0);
    check(state_o == 2'd1, "R1 no phase kept after reset", state_o, 1);
    check(pulses == 0, "R8 no pulse outside lock", pulses, 0);
    send_frame(0, 1'b0, 1'b1, pulses, at0);
    check(state_o == 2'd2, "R3 relock after reset", state_o, 2);
    check(oof_o == 1'b0, "R10 oof low when locked", oof_o, 0);

    // R9: idle cycles with data toggling leave the lock untouched
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      bit_vld_i = 1'b0; bit_i = k[0];
    end
    #1;
    check(state_o == 2'd2 && frame_start_o == 1'b0, "R9 idle hold", state_o, 2);
    send_frame(0, 1'b0, 1'b1, pulses, at0);
    check(state_o == 2'd2, "R9 phase kept across idle", state_o, 2);
    check(pulses == 1 && at0, "R8 pulse after idle", pulses, 1);

    finish_run();
  end
endmodule